// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block merges the completion interrupts of one DMA channel. Every finished descriptor produces a single-cycle completion pulse. The block counts those pulses down from a programmed threshold. When enough completions have gathered, it raises a pulse that sets the completion interrupt flag.

A second source covers the case where traffic stops before the threshold is reached. A one-shot inactivity timer restarts on each completion and advances on a prescaled tick. When it runs out, it raises a pulse that sets the delay interrupt flag, and it reloads the completion count.

The threshold and the delay are taken from fields of the channel's control word. A reload request, issued when the channel is started, refills the count. The live count and timer values are exported for status readback. The register storage and the descriptor engine sit outside this block.

Top module: `irq_coalesce`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` is 0, `tmr_o` is 0, and both `ioc_set_o` and `dly_set_o` are 0.
- R2: The threshold is `ctrl_i[23:16]`. The delay is `ctrl_i[31:24]`. No other bits of `ctrl_i` affect the block.
- R3: A completion (`cmpl_i` high at an edge) lowers the count by one. This holds unless another rule in this list reloads the count in the same cycle. A completion with the count at 0 wraps the count to 255 and raises no pulse.
- R4: A completion that finds the count at 1 reloads the count from the threshold. It also drives `ioc_set_o` high for exactly the following cycle.
- R5: `reload_i` high at an edge loads the count from the threshold. This takes precedence over the decrement. It does not suppress an `ioc_set_o` pulse due under R4.
- R6: A completion with a nonzero delay loads the timer with the delay value. This takes precedence over a tick in the same cycle, and it applies even when the timer is already running.
- R7: A tick (`tick_i` high at an edge) with no restart lowers a nonzero timer by one. Without a tick the timer holds its value. A timer at 0 stays at 0 (one-shot).
- R8: A tick that takes the timer from 1 to 0 drives `dly_set_o` high for exactly the following cycle. It also reloads the count from the threshold.
- R9: A completion with the delay at 0 leaves the timer untouched, so a delay of 0 never starts a delay interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word carrying the threshold and delay fields |
| cmpl_i | input | 1 | Completion pulse from the descriptor engine |
| reload_i | input | 1 | Count reload request on channel start |
| tick_i | input | 1 | Prescaled timer tick |
| ioc_set_o | output | 1 | One-cycle pulse that sets the completion interrupt flag |
| dly_set_o | output | 1 | One-cycle pulse that sets the delay interrupt flag |
| cnt_o | output | 8 | Live completion count |
| tmr_o | output | 8 | Live delay timer value |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it. A completion, reload or tick sampled at one edge changes `cnt_o` and `tmr_o` from that edge onward. The interrupt pulses appear in the cycle that follows that edge and are gone one edge later.

The bench drives the inputs on the falling edge and steps a behavioural model on the rising edge. It compares all four outputs on the next falling edge, so every check looks at the cycle where the result is due. Directed checks on the count, timer and pulses are placed at the same point, after the edge that consumed the stimulus and before the next stimulus is applied.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_DEC  = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;

  typedef enum logic [1:0] {
    TMR_HOLD    = 2'd0,
    TMR_DEC     = 2'd1,
    TMR_RESTART = 2'd2
  } tmr_op_e;
endpackage

// File: rtl/coal_count.sv
module coal_count
  import irq_coalesce_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmpl_i,
  input  logic         load_i,
  input  logic [W-1:0] thresh_i,
  output logic         hit_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] One = W'(1);

  logic [W-1:0] cnt_q;
  cnt_op_e      op;

  assign hit_o = cmpl_i && (cnt_q == One);

  always_comb begin
    if (load_i || hit_o) op = CNT_LOAD;
    else if (cmpl_i)     op = CNT_DEC;
    else                 op = CNT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        CNT_LOAD: cnt_q <= thresh_i;
        CNT_DEC:  cnt_q <= cnt_q - One;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/coal_timer.sv
module coal_timer
  import irq_coalesce_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] delay_i,
  input  logic         tick_i,
  output logic         expire_o,
  output logic [W-1:0] tmr_o
);
  localparam logic [W-1:0] One = W'(1);

  logic [W-1:0] tmr_q;
  tmr_op_e      op;

  always_comb begin
    if (restart_i)                   op = TMR_RESTART;
    else if (tick_i && tmr_q != '0)  op = TMR_DEC;
    else                             op = TMR_HOLD;
  end

  // one-shot: fires only on the 1 -> 0 step
  assign expire_o = (op == TMR_DEC) && (tmr_q == One);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
    end else begin
      unique case (op)
        TMR_RESTART: tmr_q <= delay_i;
        TMR_DEC:     tmr_q <= tmr_q - One;
        default:     tmr_q <= tmr_q;
      endcase
    end
  end

  assign tmr_o = tmr_q;
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coalesce_pkg::*;
#(
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TMR_W   = 8,
  parameter int unsigned THR_LSB = 16,
  parameter int unsigned DLY_LSB = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              cmpl_i,
  input  logic              reload_i,
  input  logic              tick_i,
  output logic              ioc_set_o,
  output logic              dly_set_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [TMR_W-1:0]  tmr_o
);
  logic [CNT_W-1:0] thresh;
  logic [TMR_W-1:0] delay;
  logic             restart, expire, hit;
  logic             ioc_q, dly_q;

  assign thresh  = ctrl_i[THR_LSB +: CNT_W];
  assign delay   = ctrl_i[DLY_LSB +: TMR_W];
  assign restart = cmpl_i && (delay != '0);

  coal_timer #(.W(TMR_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .delay_i   (delay),
    .tick_i    (tick_i),
    .expire_o  (expire),
    .tmr_o     (tmr_o)
  );

  coal_count #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmpl_i   (cmpl_i),
    .load_i   (reload_i || expire),
    .thresh_i (thresh),
    .hit_o    (hit),
    .cnt_o    (cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ioc_q <= 1'b0;
      dly_q <= 1'b0;
    end else begin
      ioc_q <= hit;
      dly_q <= expire;
    end
  end

  assign ioc_set_o = ioc_q;
  assign dly_set_o = dly_q;
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned TMR_W   = 8,
  parameter int unsigned THR_LSB = 16,
  parameter int unsigned DLY_LSB = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              cmpl_i,
  input logic              reload_i,
  input logic              tick_i,
  input logic              ioc_set_o,
  input logic              dly_set_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [TMR_W-1:0]  tmr_o
);
  logic [CNT_W-1:0] thr;
  logic [TMR_W-1:0] dly;
  logic             rst_w, exp_w;

  assign thr   = ctrl_i[THR_LSB +: CNT_W];
  assign dly   = ctrl_i[DLY_LSB +: TMR_W];
  assign rst_w = cmpl_i && (dly != '0);
  assign exp_w = tick_i && (tmr_o == TMR_W'(1)) && !rst_w;

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_i && !reload_i && !exp_w && (cnt_o > CNT_W'(1))
      |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  a_r4_ioc_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_i && (cnt_o == CNT_W'(1)) |=> ioc_set_o && (cnt_o == $past(thr)));

  a_r4_ioc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmpl_i && (cnt_o == CNT_W'(1))) |=> !ioc_set_o);

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_o == $past(thr));

  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_w |=> tmr_o == $past(dly));

  a_r7_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_o == '0) && !rst_w |=> tmr_o == '0);

  a_r8_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_w |=> dly_set_o && (cnt_o == $past(thr)));

  a_r8_dly_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exp_w |=> !dly_set_o);

  a_r9_zero_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_i && (dly == '0) && !tick_i |=> $stable(tmr_o));
endmodule

bind irq_coalesce irq_coalesce_chk #(
  .CTRL_W(CTRL_W), .CNT_W(CNT_W), .TMR_W(TMR_W),
  .THR_LSB(THR_LSB), .DLY_LSB(DLY_LSB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .cmpl_i(cmpl_i),
  .reload_i(reload_i), .tick_i(tick_i), .ioc_set_o(ioc_set_o),
  .dly_set_o(dly_set_o), .cnt_o(cnt_o), .tmr_o(tmr_o)
);

// File: tb/irq_coalesce_tb_top.sv
module irq_coalesce_tb_top;
  localparam int ClkPeriod = 10;
  localparam int WdogLimit = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic        cmpl = 1'b0, reload = 1'b0, tick = 1'b0;
  logic        ioc, dly;
  logic [7:0]  cnt, tmr;

  int    n_vec = 0, n_bad = 0, cycles = 0;
  string phase = "R1";
  bit    done = 1'b0;

  // behavioural model state
  int m_cnt = 0, m_tmr = 0;
  bit m_ioc = 0, m_dly = 0;

  always #(ClkPeriod/2) clk = ~clk;

  irq_coalesce dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .cmpl_i(cmpl),
    .reload_i(reload), .tick_i(tick), .ioc_set_o(ioc), .dly_set_o(dly),
    .cnt_o(cnt), .tmr_o(tmr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tmr = 0; m_ioc = 0; m_dly = 0;
    end else begin
      int thr, dl, n_cnt, n_tmr;
      bit rs, ex, hit;
      thr = int'(ctrl[23:16]);
      dl  = int'(ctrl[31:24]);
      rs  = cmpl && dl != 0;
      ex  = !rs && tick && m_tmr == 1;
      hit = cmpl && m_cnt == 1;
      if (rs)                     n_tmr = dl;
      else if (tick && m_tmr > 0) n_tmr = m_tmr - 1;
      else                        n_tmr = m_tmr;
      if (reload || ex || hit) n_cnt = thr;
      else if (cmpl)           n_cnt = (m_cnt + 255) % 256;
      else                     n_cnt = m_cnt;
      m_cnt = n_cnt; m_tmr = n_tmr; m_ioc = hit; m_dly = ex;
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      check(phase, int'(cnt), m_cnt, "cnt_o model");
      check(phase, int'(tmr), m_tmr, "tmr_o model");
      check(phase, int'(ioc), int'(m_ioc), "ioc_set_o model");
      check(phase, int'(dly), int'(m_dly), "dly_set_o model");
    end
  end

  task automatic cyc(input bit c, input bit r, input bit t);
    cmpl = c; reload = r; tick = t;
    @(posedge clk);
    @(negedge clk);
    #1;
    cmpl = 0; reload = 0; tick = 0;
  endtask

  function automatic logic [31:0] mk(input int thr, input int dl, input logic [15:0] junk);
    return {dl[7:0], thr[7:0], junk};
  endfunction

  initial begin
    #1;
    check("R1", int'(cnt), 0, "cnt_o in reset");
    check("R1", int'(tmr), 0, "tmr_o in reset");
    check("R1", int'(ioc) + int'(dly), 0, "pulses in reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;

    phase = "R4";
    cyc(1, 0, 0);
    check("R4", int'(cnt), 255, "wrap from zero");
    check("R4", int'(ioc), 0, "no pulse on wrap");

    phase = "R5";
    ctrl = mk(3, 0, 16'hFFFF);
    cyc(0, 1, 0);
    check("R2", int'(cnt), 3, "threshold field load");

    phase = "R3";
    cyc(1, 0, 0);
    check("R3", int'(cnt), 2, "decrement");
    cyc(1, 0, 0);
    check("R3", int'(cnt), 1, "decrement");
    phase = "R4";
    cyc(1, 0, 0);
    check("R4", int'(ioc), 1, "ioc pulse");
    check("R4", int'(cnt), 3, "reload on hit");
    cyc(0, 0, 0);
    check("R4", int'(ioc), 0, "ioc one cycle");

    phase = "R6";
    ctrl = mk(3, 5, 16'h0000);
    cyc(1, 0, 1);
    check("R6", int'(tmr), 5, "restart beats tick");
    check("R2", int'(cnt), 2, "count after completion");
    cyc(0, 0, 1); cyc(0, 0, 1);
    cyc(1, 0, 0);
    check("R6", int'(tmr), 5, "restart while running");
    phase = "R7";
    cyc(0, 0, 0);
    check("R7", int'(tmr), 5, "hold without tick");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    check("R7", int'(tmr), 1, "tick decrements");
    phase = "R8";
    cyc(0, 0, 1);
    check("R8", int'(dly), 1, "delay pulse");
    check("R8", int'(cnt), 3, "reload on expiry");
    check("R8", int'(tmr), 0, "timer at zero");
    phase = "R7";
    cyc(0, 0, 1);
    check("R8", int'(dly), 0, "delay pulse one cycle");
    check("R7", int'(tmr), 0, "one-shot stays zero");

    phase = "R9";
    ctrl = mk(3, 0, 16'h0000);
    cyc(1, 0, 0);
    check("R9", int'(tmr), 0, "zero delay leaves timer");
    cyc(0, 0, 1);
    check("R9", int'(dly), 0, "no delay pulse");

    phase = "R5";
    ctrl = mk(7, 0, 16'h0000);
    cyc(1, 1, 0);
    check("R5", int'(cnt), 7, "reload beats decrement");

    phase = "R3";
    for (int i = 0; i < 3000; i++) begin
      if (i % 97 == 0) ctrl = mk(int'($urandom_range(0, 4)), int'($urandom_range(0, 4)), 16'($urandom));
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, 15) == 0, $urandom_range(0, 1) == 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > WdogLimit);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WdogLimit);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule